// File: doc/BRIEF.md
# Renaming Reservation Station Pool

This block holds the waiting instructions for one class of functional unit and renames their register operands as they arrive. It contains a small set of stations, an architectural register file and a table that records, for each register, which station will produce its next value. An instruction that is issued takes a free station. Each source operand is either copied as a value or replaced by the tag of the station that still owes it. The instruction's destination register is then claimed by the new station's tag.

Results come back on a single broadcast bus that carries a tag and a value. Every station that waits on that tag copies the value. The register file accepts the value only if the broadcasting tag is still the one recorded as the register's latest producer, so an older write to the same register cannot overwrite a newer one. Once both operands of a station are present, it competes for the functional unit, and the oldest such station is offered first. A station is released when its own result appears on the bus.

Top module: `rename_station_pool`

## Requirements
- R1: After reset every station is free, `iss_ready` is 1, `iss_tag` is 1, `disp_valid` is 0, and every register reads value 0 with producer tag 0 (tag 0 means the value is present).
- R2: `iss_tag` shows the tag of the lowest-numbered free station, where station k (from 0) carries tag k+1. An issue is taken when `iss_valid` and `iss_ready` are both high. With every station busy, `iss_ready` is 0, `iss_tag` is 0 and `iss_valid` has no effect on any register's producer tag.
- R3: A source register whose producer tag is 0 is captured at issue with its register file value.
- R4: A source register whose producer broadcasts in the same cycle as the issue takes the bus value directly, and the instruction needs no later broadcast for that operand.
- R5: A pending operand copies the bus value when the broadcast tag equals its recorded producer tag. The station can be dispatched from the following cycle.
- R6: `disp_valid` is high only while some undispatched station has both operands. It presents that station's operation, both operand values and its tag. The station counts as dispatched in a cycle when `disp_ready` is high.
- R7: When several stations are ready, the one issued earliest is offered, whatever its station number.
- R8: An accepted issue records the new station's tag as the producer of the destination register from the next cycle.
- R9: A broadcast writes a register's value and clears its producer tag only when the register's recorded tag equals the broadcast tag. A broadcast from a superseded producer leaves the register's value and tag unchanged.
- R10: A dispatched station is freed by the broadcast of its own tag and can be allocated again from the next cycle.
- R11: A station that has been dispatched is not offered again while it waits for its broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 4 | Operation code of the issued instruction |
| iss_src1 | input | 3 | First source register |
| iss_src2 | input | 3 | Second source register |
| iss_dst | input | 3 | Destination register |
| iss_ready | output | 1 | A station is free |
| iss_tag | output | 3 | Tag the next accepted issue receives (0 when full) |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | 3 | Tag of the broadcasting station |
| cdb_value | input | 16 | Broadcast result value |
| disp_valid | output | 1 | A ready station is offered |
| disp_ready | input | 1 | Functional unit accepts the offer |
| disp_op | output | 4 | Offered operation code |
| disp_a | output | 16 | Offered first operand |
| disp_b | output | 16 | Offered second operand |
| disp_tag | output | 3 | Tag of the offered station |
| rf_raddr | input | 3 | Register observation address |
| rf_rdata | output | 16 | Value of the observed register |
| rf_rtag | output | 3 | Producer tag of the observed register |

## Verification
Registers are first loaded through ordinary issue, dispatch and broadcast cycles. This shows that claims and conditional writes work in isolation. A two-instruction chain separates operands read from the register file from operands woken by the bus. An issue made in the same cycle as its producer's broadcast shows whether the bypass works, because without it that instruction would wait forever on a tag that has already gone by. A pair of writes to the same register checks that a stale broadcast is ignored. A station reused out of numeric order shows that age, not index, picks the dispatch. Filling every station checks the stall and that an issue made while full is dropped.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

    localparam int NUM_RS  = 4;
    localparam int NUM_REG = 8;
    localparam int DATA_W  = 16;
    localparam int OP_W    = 4;
    localparam int TAG_W   = $clog2(NUM_RS + 1);
    localparam int REG_W   = $clog2(NUM_REG);

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [OP_W-1:0]   op_t;
    typedef logic [REG_W-1:0]  reg_t;

    // An operand: tag 0 means val holds the operand.
    typedef struct packed {
        tag_t  tag;
        data_t val;
    } opnd_t;

    typedef struct packed {
        logic  busy;
        logic  sent;
        op_t   op;
        opnd_t a;
        opnd_t b;
    } slot_t;

    // Capture a broadcast value into an operand that waits on it.
    function automatic opnd_t snoop(opnd_t cur, logic bus_v, tag_t bus_t, data_t bus_d);
        opnd_t nxt;
        nxt = cur;
        if (bus_v && cur.tag != '0 && cur.tag == bus_t) begin
            nxt.tag = '0;
            nxt.val = bus_d;
        end
        return nxt;
    endfunction

    function automatic logic slot_ready(slot_t s);
        return s.busy && !s.sent && s.a.tag == '0 && s.b.tag == '0;
    endfunction

endpackage

// File: rtl/rsp_regstat.sv
module rsp_regstat
    import rsp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  reg_t  src1_addr,
    input  reg_t  src2_addr,
    output opnd_t src1,
    output opnd_t src2,
    input  logic  claim_en,
    input  reg_t  claim_reg,
    input  tag_t  claim_tag,
    input  logic  bus_valid,
    input  tag_t  bus_tag,
    input  data_t bus_value,
    input  reg_t  peek_addr,
    output data_t peek_val,
    output tag_t  peek_tag
);

    data_t val_q [NUM_REG];
    tag_t  own_q [NUM_REG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NUM_REG; r++) begin
                val_q[r] <= '0;
                own_q[r] <= '0;
            end
        end else begin
            for (int r = 0; r < NUM_REG; r++) begin
                if (bus_valid && own_q[r] != '0 && own_q[r] == bus_tag) begin
                    val_q[r] <= bus_value;
                    own_q[r] <= '0;
                end
                // A new claim overrides a clear in the same cycle.
                if (claim_en && claim_reg == reg_t'(r))
                    own_q[r] <= claim_tag;
            end
        end
    end

    always_comb begin
        src1.tag = own_q[src1_addr];
        src1.val = val_q[src1_addr];
        src2.tag = own_q[src2_addr];
        src2.val = val_q[src2_addr];
        peek_val = val_q[peek_addr];
        peek_tag = own_q[peek_addr];
    end

endmodule

// File: rtl/rsp_slot.sv
module rsp_slot
    import rsp_pkg::*;
#(
    parameter tag_t SLOT_TAG = tag_t'(1)
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  op_t   load_op,
    input  opnd_t load_a,
    input  opnd_t load_b,
    input  logic  bus_valid,
    input  tag_t  bus_tag,
    input  data_t bus_value,
    input  logic  taken,
    output slot_t state,
    output logic  ready
);

    slot_t s_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else if (load) begin
            s_q.busy <= 1'b1;
            s_q.sent <= 1'b0;
            s_q.op   <= load_op;
            s_q.a    <= load_a;
            s_q.b    <= load_b;
        end else if (s_q.busy) begin
            if (s_q.sent && bus_valid && bus_tag == SLOT_TAG) begin
                s_q.busy <= 1'b0;
                s_q.sent <= 1'b0;
            end else begin
                if (taken)
                    s_q.sent <= 1'b1;
                s_q.a <= snoop(s_q.a, bus_valid, bus_tag, bus_value);
                s_q.b <= snoop(s_q.b, bus_valid, bus_tag, bus_value);
            end
        end
    end

    assign state = s_q;
    assign ready = slot_ready(s_q);

endmodule

// File: rtl/rsp_age_pick.sv
module rsp_age_pick #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] alloc,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);

    // older_q[i][j] set: slot i was allocated before slot j.
    logic [N-1:0] older_q [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++)
                older_q[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (alloc[i]) begin
                    older_q[i] <= '0;
                    for (int j = 0; j < N; j++)
                        if (j != i)
                            older_q[j][i] <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        grant = '0;
        for (int i = 0; i < N; i++) begin
            logic beaten;
            beaten = 1'b0;
            for (int j = 0; j < N; j++)
                beaten = beaten | (req[j] & older_q[j][i]);
            grant[i] = req[i] & ~beaten;
        end
    end

endmodule

// File: rtl/rename_station_pool.sv
module rename_station_pool
    import rsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [REG_W-1:0]  iss_src1,
    input  logic [REG_W-1:0]  iss_src2,
    input  logic [REG_W-1:0]  iss_dst,
    output logic              iss_ready,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    output logic              disp_valid,
    input  logic              disp_ready,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_a,
    output logic [DATA_W-1:0] disp_b,
    output logic [TAG_W-1:0]  disp_tag,
    input  logic [REG_W-1:0]  rf_raddr,
    output logic [DATA_W-1:0] rf_rdata,
    output logic [TAG_W-1:0]  rf_rtag
);

    slot_t              slots [NUM_RS];
    logic [NUM_RS-1:0]  busy_v;
    logic [NUM_RS-1:0]  ready_v;
    logic [NUM_RS-1:0]  alloc_v;
    logic [NUM_RS-1:0]  grant;
    logic [NUM_RS-1:0]  taken_v;
    opnd_t              rf_src1, rf_src2;
    opnd_t              new_a, new_b;
    logic               iss_fire;

    // Lowest free slot.
    always_comb begin
        iss_ready = 1'b0;
        iss_tag   = '0;
        for (int i = NUM_RS - 1; i >= 0; i--) begin
            if (!busy_v[i]) begin
                iss_ready = 1'b1;
                iss_tag   = tag_t'(i + 1);
            end
        end
    end

    assign iss_fire = iss_valid && iss_ready;

    always_comb begin
        for (int i = 0; i < NUM_RS; i++)
            alloc_v[i] = iss_fire && iss_tag == tag_t'(i + 1);
    end

    rsp_regstat u_regstat (
        .clk       (clk),
        .rst       (rst),
        .src1_addr (iss_src1),
        .src2_addr (iss_src2),
        .src1      (rf_src1),
        .src2      (rf_src2),
        .claim_en  (iss_fire),
        .claim_reg (iss_dst),
        .claim_tag (iss_tag),
        .bus_valid (cdb_valid),
        .bus_tag   (cdb_tag),
        .bus_value (cdb_value),
        .peek_addr (rf_raddr),
        .peek_val  (rf_rdata),
        .peek_tag  (rf_rtag)
    );

    // Same-cycle broadcast resolves the operand at issue.
    assign new_a = snoop(rf_src1, cdb_valid, cdb_tag, cdb_value);
    assign new_b = snoop(rf_src2, cdb_valid, cdb_tag, cdb_value);

    for (genvar g = 0; g < NUM_RS; g++) begin : g_slot
        rsp_slot #(
            .SLOT_TAG (tag_t'(g + 1))
        ) u_slot (
            .clk       (clk),
            .rst       (rst),
            .load      (alloc_v[g]),
            .load_op   (iss_op),
            .load_a    (new_a),
            .load_b    (new_b),
            .bus_valid (cdb_valid),
            .bus_tag   (cdb_tag),
            .bus_value (cdb_value),
            .taken     (taken_v[g]),
            .state     (slots[g]),
            .ready     (ready_v[g])
        );
        assign busy_v[g]  = slots[g].busy;
        assign taken_v[g] = grant[g] && disp_ready;
    end

    rsp_age_pick #(
        .N (NUM_RS)
    ) u_age (
        .clk   (clk),
        .rst   (rst),
        .alloc (alloc_v),
        .req   (ready_v),
        .grant (grant)
    );

    always_comb begin
        disp_valid = |grant;
        disp_op    = '0;
        disp_a     = '0;
        disp_b     = '0;
        disp_tag   = '0;
        for (int i = 0; i < NUM_RS; i++) begin
            if (grant[i]) begin
                disp_op  = slots[i].op;
                disp_a   = slots[i].a.val;
                disp_b   = slots[i].b.val;
                disp_tag = tag_t'(i + 1);
            end
        end
    end

endmodule

// File: rtl/rsp_checker.sv
module rsp_checker
    import rsp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              iss_valid,
    input logic              iss_ready,
    input logic [TAG_W-1:0]  iss_tag,
    input logic [REG_W-1:0]  iss_dst,
    input logic              cdb_valid,
    input logic [TAG_W-1:0]  cdb_tag,
    input logic [DATA_W-1:0] cdb_value,
    input logic              disp_valid,
    input logic              disp_ready,
    input logic [TAG_W-1:0]  disp_tag,
    input logic [REG_W-1:0]  rf_raddr,
    input logic [DATA_W-1:0] rf_rdata,
    input logic [TAG_W-1:0]  rf_rtag,
    input logic [NUM_RS-1:0] grant
);

    a_r2_tag_range: assert property (@(posedge clk) disable iff (rst)
        iss_ready |-> (iss_tag != '0 && int'(iss_tag) <= NUM_RS));

    a_r2_full_tag: assert property (@(posedge clk) disable iff (rst)
        !iss_ready |-> iss_tag == '0);

    a_r6_disp_range: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> (disp_tag != '0 && int'(disp_tag) <= NUM_RS));

    a_r7_one_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    a_r8_claim: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_ready && iss_dst == rf_raddr)
        |=> (rf_raddr != $past(rf_raddr)) || (rf_rtag == $past(iss_tag)));

    a_r9_match_write: assert property (@(posedge clk) disable iff (rst)
        (cdb_valid && rf_rtag != '0 && rf_rtag == cdb_tag)
        |=> (rf_raddr != $past(rf_raddr)) || (rf_rdata == $past(cdb_value)));

    a_r9_stale_keep: assert property (@(posedge clk) disable iff (rst)
        !(cdb_valid && rf_rtag != '0 && rf_rtag == cdb_tag)
        |=> (rf_raddr != $past(rf_raddr)) || $stable(rf_rdata));

    a_r11_no_resend: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_ready)
        |=> !(disp_valid && disp_tag == $past(disp_tag)));

endmodule

bind rename_station_pool rsp_checker u_rsp_checker (
    .clk        (clk),
    .rst        (rst),
    .iss_valid  (iss_valid),
    .iss_ready  (iss_ready),
    .iss_tag    (iss_tag),
    .iss_dst    (iss_dst),
    .cdb_valid  (cdb_valid),
    .cdb_tag    (cdb_tag),
    .cdb_value  (cdb_value),
    .disp_valid (disp_valid),
    .disp_ready (disp_ready),
    .disp_tag   (disp_tag),
    .rf_raddr   (rf_raddr),
    .rf_rdata   (rf_rdata),
    .rf_rtag    (rf_rtag),
    .grant      (grant)
);

// File: tb/rename_station_pool_bench.sv
module rename_station_pool_bench;
    import rsp_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iss_valid = 1'b0;
    op_t         iss_op = '0;
    reg_t        iss_src1 = '0, iss_src2 = '0, iss_dst = '0;
    logic        iss_ready;
    tag_t        iss_tag;
    logic        cdb_valid = 1'b0;
    tag_t        cdb_tag = '0;
    data_t       cdb_value = '0;
    logic        disp_valid;
    logic        disp_ready = 1'b0;
    op_t         disp_op;
    data_t       disp_a, disp_b;
    tag_t        disp_tag;
    reg_t        rf_raddr = '0;
    data_t       rf_rdata;
    tag_t        rf_rtag;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Register preload vectors: {register, value}; expected read-back = value.
    localparam logic [18:0] LOAD_VEC [6] = '{
        {3'd1, 16'h0011}, {3'd2, 16'h0022}, {3'd3, 16'h0033},
        {3'd4, 16'h0044}, {3'd5, 16'h0055}, {3'd6, 16'h0066}
    };

    always #10 clk = ~clk;

    rename_station_pool u_rename_station_pool (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(op_t op, reg_t s1, reg_t s2, reg_t d);
        iss_valid = 1'b1;
        iss_op    = op;
        iss_src1  = s1;
        iss_src2  = s2;
        iss_dst   = d;
    endtask

    task automatic bcast(tag_t t, data_t v);
        cdb_valid = 1'b1;
        cdb_tag   = t;
        cdb_value = v;
    endtask

    task automatic drain();
        for (int k = 0; k < 8; k++) begin
            tag_t t;
            @(negedge clk);
            cdb_valid = 1'b0;
            #1;
            if (!disp_valid) break;
            t = disp_tag;
            disp_ready = 1'b1;
            @(negedge clk);
            disp_ready = 1'b0;
            bcast(t, 16'h0000);
        end
        cdb_valid = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 iss_ready", 32'(iss_ready), 32'd1);
        check("R1 iss_tag", 32'(iss_tag), 32'd1);
        check("R1 disp_valid", 32'(disp_valid), 32'd0);
        for (int r = 0; r < NUM_REG; r++) begin
            rf_raddr = reg_t'(r);
            #1;
            check("R1 reg tag", 32'(rf_rtag), 32'd0);
            check("R1 reg value", 32'(rf_rdata), 32'd0);
        end

        // Table-driven preload: issue, dispatch, broadcast, read back.
        for (int i = 0; i < 6; i++) begin
            reg_t  r;
            data_t v;
            r = LOAD_VEC[i][18:16];
            v = LOAD_VEC[i][15:0];
            @(negedge clk);
            issue(4'd0, 3'd0, 3'd0, r);
            #1 check("R2 load tag", 32'(iss_tag), 32'd1);
            @(negedge clk);
            iss_valid = 1'b0;
            rf_raddr = r;
            disp_ready = 1'b1;
            #1 check("R8 load claim", 32'(rf_rtag), 32'd1);
            check("R6 load ready", 32'(disp_valid), 32'd1);
            @(negedge clk);
            disp_ready = 1'b0;
            bcast(3'd1, v);
            @(negedge clk);
            cdb_valid = 1'b0;
            #1 check("R9 load value", 32'(rf_rdata), 32'(v));
            check("R9 load tag clear", 32'(rf_rtag), 32'd0);
            check("R10 load free", 32'(iss_ready), 32'd1);
        end

        // Dependent chain: R3, R5, R6, R11
        @(negedge clk);
        issue(4'd2, 3'd1, 3'd2, 3'd4);
        #1 check("R2 chain first tag", 32'(iss_tag), 32'd1);
        @(negedge clk);
        issue(4'd3, 3'd4, 3'd1, 3'd5);
        #1 check("R2 chain second tag", 32'(iss_tag), 32'd2);
        @(negedge clk);
        iss_valid = 1'b0;
        #1 check("R6 chain valid", 32'(disp_valid), 32'd1);
        check("R6 chain tag", 32'(disp_tag), 32'd1);
        check("R6 chain op", 32'(disp_op), 32'd2);
        check("R3 chain a", 32'(disp_a), 32'h0011);
        check("R3 chain b", 32'(disp_b), 32'h0022);
        disp_ready = 1'b1;
        @(negedge clk);
        disp_ready = 1'b0;
        #1 check("R11 no resend, R6 waiting", 32'(disp_valid), 32'd0);
        bcast(3'd1, 16'h0111);
        @(negedge clk);
        cdb_valid = 1'b0;
        rf_raddr = 3'd4;
        #1 check("R5 woken valid", 32'(disp_valid), 32'd1);
        check("R5 woken tag", 32'(disp_tag), 32'd2);
        check("R5 woken a", 32'(disp_a), 32'h0111);
        check("R3 second b", 32'(disp_b), 32'h0011);
        check("R10 freed lowest", 32'(iss_tag), 32'd1);
        check("R9 chain write", 32'(rf_rdata), 32'h0111);
        disp_ready = 1'b1;
        @(negedge clk);
        disp_ready = 1'b0;
        bcast(3'd2, 16'h0222);
        @(negedge clk);
        cdb_valid = 1'b0;
        rf_raddr = 3'd5;
        #1 check("R9 chain second write", 32'(rf_rdata), 32'h0222);

        // Bypass at issue: R4
        @(negedge clk);
        issue(4'd1, 3'd1, 3'd0, 3'd6);
        @(negedge clk);
        iss_valid = 1'b0;
        #1 check("R6 bypass producer", 32'(disp_tag), 32'd1);
        disp_ready = 1'b1;
        @(negedge clk);
        disp_ready = 1'b0;
        issue(4'd5, 3'd6, 3'd6, 3'd7);
        bcast(3'd1, 16'h05A5);
        #1 check("R2 bypass tag", 32'(iss_tag), 32'd2);
        @(negedge clk);
        iss_valid = 1'b0;
        cdb_valid = 1'b0;
        #1 check("R4 bypass valid", 32'(disp_valid), 32'd1);
        check("R4 bypass tag", 32'(disp_tag), 32'd2);
        check("R4 bypass a", 32'(disp_a), 32'h05A5);
        check("R4 bypass b", 32'(disp_b), 32'h05A5);
        disp_ready = 1'b1;
        @(negedge clk);
        disp_ready = 1'b0;
        bcast(3'd2, 16'h0777);
        @(negedge clk);
        cdb_valid = 1'b0;
        rf_raddr = 3'd6;
        #1 check("R9 bypass producer write", 32'(rf_rdata), 32'h05A5);
        rf_raddr = 3'd7;
        #1 check("R9 bypass consumer write", 32'(rf_rdata), 32'h0777);

        // Two writers of one register: R8, R9
        @(negedge clk);
        issue(4'd4, 3'd2, 3'd2, 3'd1);
        @(negedge clk);
        issue(4'd4, 3'd3, 3'd3, 3'd1);
        @(negedge clk);
        iss_valid = 1'b0;
        rf_raddr = 3'd1;
        #1 check("R8 latest claim", 32'(rf_rtag), 32'd2);
        check("R7 waw first", 32'(disp_tag), 32'd1);
        disp_ready = 1'b1;
        @(negedge clk);
        disp_ready = 1'b0;
        bcast(3'd1, 16'h0BAD);
        #1 check("R7 waw second", 32'(disp_tag), 32'd2);
        @(negedge clk);
        cdb_valid = 1'b0;
        #1 check("R9 stale value kept", 32'(rf_rdata), 32'h0011);
        check("R9 stale tag kept", 32'(rf_rtag), 32'd2);
        disp_ready = 1'b1;
        @(negedge clk);
        disp_ready = 1'b0;
        bcast(3'd2, 16'h600D);
        @(negedge clk);
        cdb_valid = 1'b0;
        #1 check("R9 latest value", 32'(rf_rdata), 32'h600D);
        check("R9 latest tag clear", 32'(rf_rtag), 32'd0);

        // Age over index: R7
        @(negedge clk);
        issue(4'd6, 3'd2, 3'd3, 3'd7);
        @(negedge clk);
        issue(4'd7, 3'd2, 3'd3, 3'd7);
        @(negedge clk);
        iss_valid = 1'b0;
        #1 check("R7 first offer", 32'(disp_tag), 32'd1);
        disp_ready = 1'b1;
        @(negedge clk);
        disp_ready = 1'b0;
        bcast(3'd1, 16'h0001);
        @(negedge clk);
        cdb_valid = 1'b0;
        issue(4'd1, 3'd2, 3'd3, 3'd7);
        #1 check("R10 reuse slot", 32'(iss_tag), 32'd1);
        @(negedge clk);
        iss_valid = 1'b0;
        #1 check("R7 older high slot", 32'(disp_tag), 32'd2);
        check("R7 older op", 32'(disp_op), 32'd7);
        disp_ready = 1'b1;
        @(negedge clk);
        #1 check("R7 younger next", 32'(disp_tag), 32'd1);
        check("R7 younger op", 32'(disp_op), 32'd1);
        @(negedge clk);
        disp_ready = 1'b0;
        bcast(3'd2, 16'h00BB);
        @(negedge clk);
        bcast(3'd1, 16'h00CC);
        @(negedge clk);
        cdb_valid = 1'b0;
        rf_raddr = 3'd7;
        #1 check("R9 reused tag write", 32'(rf_rdata), 32'h00CC);
        check("R9 reused tag clear", 32'(rf_rtag), 32'd0);
        check("R10 all free", 32'(iss_ready), 32'd1);

        // Fill every slot: R2
        for (int k = 0; k < NUM_RS; k++) begin
            @(negedge clk);
            issue(op_t'(k), 3'd2, 3'd3, 3'd7);
            #1 check("R2 fill order", 32'(iss_tag), 32'(k + 1));
        end
        @(negedge clk);
        issue(4'd9, 3'd2, 3'd3, 3'd5);
        #1 check("R2 full stall", 32'(iss_ready), 32'd0);
        check("R2 full tag", 32'(iss_tag), 32'd0);
        @(negedge clk);
        iss_valid = 1'b0;
        rf_raddr = 3'd5;
        #1 check("R2 ignored claim", 32'(rf_rtag), 32'd0);
        check("R2 ignored value", 32'(rf_rdata), 32'h0222);
        check("R7 full oldest", 32'(disp_tag), 32'd1);
        drain();
        @(negedge clk);
        #1 check("R10 drained ready", 32'(iss_ready), 32'd1);
        check("R10 drained tag", 32'(iss_tag), 32'd1);
        check("R6 drained idle", 32'(disp_valid), 32'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule